// File: doc/BRIEF.md
# Routed Interrupt Matrix with Read-to-Clear Pending Status

This block sits between a cluster's interrupt sources and its cores. It takes a vector of interrupt inputs, which may be held levels or one-cycle pulses, and drives a set of output lines. Output lines come in groups of four, one group per core. Every output line has a private register window. The window holds a one-byte enable for each input and three 64-bit pending-status words. Any input can be routed to any combination of outputs, and each routing latches its own pending bit on its own output.

An output line is high while at least one pending bit is latched for it. A software handler on the core reads the three status words of its line to learn which inputs fired. Each such read also clears the bits it returned. Access is through a simple request/response bus. Every request gets a response in the cycle after it. Byte accesses reach the enables and 64-bit accesses reach the status words.

Top module: `irq_router`

## Requirements
- R1: After a synchronous active-low reset, every enable on every line is 0, no pending bit is set, every output is low, and no response is pending.
- R2: A byte write (size 0) to offset n of a line window, with n below the input count, stores bit 0 of the written byte as the enable of input n for that line. A byte read of that offset returns 0x00 or 0x01 in bits 7:0 and zero in all higher bits.
- R3: A pending bit is latched for input n on line k at a clock edge where input n is high and its enable on line k is 1. Input n is reported at bit n mod 64 of the status word at offset 0x120 + 8 * (n div 64), read as a 64-bit access (size 1).
- R4: A 64-bit read of a status word returns the latched bits and clears them. A following read of the same word returns 0 unless the bits were set again.
- R5: When an input sets a pending bit on the same edge as a read that clears it, the bit stays set. The read still returns the bit.
- R6: Output k rises one cycle after its first pending bit is latched. It falls one cycle after its last pending bit is cleared.
- R7: A pulse on a disabled input latches nothing. A pulse on an enabled input stays latched after the input falls, until it is read.
- R8: Lines are independent. One input enabled on several lines latches on each of them, and a status read on one line leaves the pending bits of the others untouched.
- R9: The window of line g * 4 + j starts at byte address g * 0x1000 + j * 0x400.
- R10: Status bit positions at or above the input count always read as 0. Writes to status offsets change nothing.
- R11: Each request is answered with resp_valid high in the next cycle, and resp_valid is low in cycles that follow no request. Offsets that are not mapped, and accesses of the wrong size, read as zero and have no effect. This includes a byte read of a status offset, which does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | N_IN (139) | Interrupt inputs, level or pulse |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = byte access, 1 = 64-bit access |
| req_addr | input | ADDR_W (17) | Byte address |
| req_wdata | input | 64 | Write data; a byte write uses bit 0 |
| resp_valid | output | 1 | Response for the request of the previous cycle |
| resp_rdata | output | 64 | Read data, zero for writes |
| irq_out | output | N_OUT (72) | Output lines, bit g * 4 + j for group g line j |

## Verification
The routing is exercised with a single input enabled on one line and with several inputs spread over all three status words. It is also exercised with one input enabled on lines in different groups, and with inputs that pulse for one cycle against inputs held high across a clearing read. The single-word cases show the bit placement. The multi-line case separates per-line pending storage from a shared one. The held input shows whether set wins over clear. Pulses on disabled inputs, reads with the wrong access size, and writes to status offsets show that nothing latches or clears where it should not.

// File: rtl/irq_router_pkg.sv
// Package: shared constants and types of the interrupt routing matrix.
// Assumes a fixed 0x400-byte window per output line and 64-bit status words.
package irq_router_pkg;

    // Kind of register targeted by a bus request
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_ENABLE = 2'd1,
        ACC_STATUS = 2'd2
    } acc_kind_e;

    // Bytes per output-line window, as an address bit count (0x400)
    localparam int unsigned WIN_W = 10;
    // Bits in one pending-status word
    localparam int unsigned WORD_BITS = 64;
    // Offset of the first status word inside a window
    localparam logic [WIN_W-1:0] STATUS_BASE = 10'h120;

endpackage

// File: rtl/irq_addr_decode.sv
// Module: splits a bus address into line, register kind and index.
// Assumes LINES_PER_GROUP is a power of two and N_IN does not reach the
// status offsets, so the enable bytes and the status words never overlap.
module irq_addr_decode
    import irq_router_pkg::*;
#(
    parameter int N_IN            = 139,
    parameter int N_GROUPS        = 18,
    parameter int LINES_PER_GROUP = 4,
    parameter int N_WORDS         = 3,
    parameter int ADDR_W          = 17,
    parameter int LINE_W          = 7,
    parameter int IDX_W           = 8,
    parameter int WSEL_W          = 2
) (
    input  logic              req_size,
    input  logic [ADDR_W-1:0] req_addr,
    output acc_kind_e         kind,
    output logic [LINE_W-1:0] line,
    output logic [IDX_W-1:0]  idx,
    output logic [WSEL_W-1:0] wsel
);
    localparam int LSEL_W = $clog2(LINES_PER_GROUP);
    localparam int GRP_W  = ADDR_W - WIN_W - LSEL_W;
    localparam logic [GRP_W:0]   N_GRP_L  = (GRP_W+1)'(N_GROUPS);
    localparam logic [WIN_W-1:0] N_IN_L   = WIN_W'(N_IN);
    localparam logic [WIN_W-1:0] STAT_END = STATUS_BASE + WIN_W'(8 * N_WORDS);

    logic [GRP_W-1:0]  grp;
    logic [LSEL_W-1:0] lsel;
    logic [WIN_W-1:0]  off;
    logic [WIN_W-1:0]  soff;

    // Split the address into group, line-in-group and window offset
    assign grp  = req_addr[ADDR_W-1 -: GRP_W];
    assign lsel = req_addr[WIN_W +: LSEL_W];
    assign off  = req_addr[WIN_W-1:0];
    assign soff = off - STATUS_BASE;
    assign line = LINE_W'({grp, lsel});

    // Classify the access by group range, size and offset
    always_comb begin
        kind = ACC_NONE;
        idx  = IDX_W'(off);
        wsel = WSEL_W'(soff >> 3);
        if ({1'b0, grp} < N_GRP_L) begin
            if (!req_size && off < N_IN_L) begin
                kind = ACC_ENABLE;
            end else if (req_size && off >= STATUS_BASE && off < STAT_END
                         && off[2:0] == 3'b000) begin
                kind = ACC_STATUS;
            end
        end
    end

endmodule

// File: rtl/irq_line_slice.sv
// Module: state of one output line, with the per-input enable bits, the
// latched pending bits and the registered output.
// Assumes the decoder raises at most one of en_we / clr_req per cycle and
// only for indices inside the input range.
module irq_line_slice
    import irq_router_pkg::*;
#(
    parameter int N_IN   = 139,
    parameter int IDX_W  = 8,
    parameter int WSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   irq_in,
    input  logic              en_we,
    input  logic [IDX_W-1:0]  en_idx,
    input  logic              en_wbit,
    input  logic              clr_req,
    input  logic [WSEL_W-1:0] clr_wsel,
    output logic [N_IN-1:0]   en_vec,
    output logic [N_IN-1:0]   pend_vec,
    output logic              irq_out
);
    logic [N_IN-1:0] clr_mask;

    // Update the enable bit that a byte write targets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_vec <= '0;
        end else if (en_we) begin
            en_vec[en_idx] <= en_wbit;
        end
    end

    // Mark the pending bits covered by the status word being read
    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            clr_mask[i] = clr_req && (WSEL_W'(i / WORD_BITS) == clr_wsel);
        end
    end

    // Latch pending bits; a new set overrides a clearing read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vec <= '0;
        end else begin
            pend_vec <= (pend_vec & ~clr_mask) | (irq_in & en_vec);
        end
    end

    // Drive the output from the latched bits, one cycle behind them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out <= 1'b0;
        end else begin
            irq_out <= |pend_vec;
        end
    end

endmodule

// File: rtl/irq_read_mux.sv
// Module: picks the read data for the addressed line and register.
// Assumes line and idx are inside range whenever kind is not ACC_NONE.
module irq_read_mux
    import irq_router_pkg::*;
#(
    parameter int N_IN    = 139,
    parameter int N_OUT   = 72,
    parameter int N_WORDS = 3,
    parameter int LINE_W  = 7,
    parameter int IDX_W   = 8,
    parameter int WSEL_W  = 2
) (
    input  logic                        rd_en,
    input  acc_kind_e                   kind,
    input  logic [LINE_W-1:0]           line,
    input  logic [IDX_W-1:0]            idx,
    input  logic [WSEL_W-1:0]           wsel,
    input  logic [N_OUT-1:0][N_IN-1:0]  en_all,
    input  logic [N_OUT-1:0][N_IN-1:0]  pend_all,
    output logic [WORD_BITS-1:0]        rdata_next
);
    logic [N_WORDS*WORD_BITS-1:0] padded;

    // Zero-extend the selected line's pending bits to whole words
    always_comb begin
        padded = '0;
        padded[N_IN-1:0] = pend_all[line];
    end

    // Select enable byte or status word; everything else reads zero
    always_comb begin
        rdata_next = '0;
        if (rd_en) begin
            if (kind == ACC_ENABLE) begin
                rdata_next[0] = en_all[line][idx];
            end else if (kind == ACC_STATUS) begin
                rdata_next = padded[int'(wsel) * WORD_BITS +: WORD_BITS];
            end
        end
    end

endmodule

// File: rtl/irq_router.sv
// Module: top of the interrupt routing matrix. It instantiates one state
// slice per output line, the address decoder and the read mux, and it
// registers the bus response. Assumes a single-cycle request with a
// response one cycle later, and no back-pressure.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int N_IN            = 139,
    parameter int N_GROUPS        = 18,
    parameter int LINES_PER_GROUP = 4,
    localparam int N_OUT   = N_GROUPS * LINES_PER_GROUP,
    localparam int N_WORDS = (N_IN + WORD_BITS - 1) / WORD_BITS,
    localparam int ADDR_W  = $clog2(N_GROUPS) + $clog2(LINES_PER_GROUP) + WIN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_IN-1:0]      irq_in,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_size,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [WORD_BITS-1:0] req_wdata,
    output logic                 resp_valid,
    output logic [WORD_BITS-1:0] resp_rdata,
    output logic [N_OUT-1:0]     irq_out
);
    localparam int LINE_W = $clog2(N_OUT);
    localparam int IDX_W  = $clog2(N_IN);
    localparam int WSEL_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

    acc_kind_e                  kind;
    logic [LINE_W-1:0]          line;
    logic [IDX_W-1:0]           idx;
    logic [WSEL_W-1:0]          wsel;
    logic                       en_we;
    logic                       clr_req;
    logic                       rd_en;
    logic [N_OUT-1:0][N_IN-1:0] en_all;
    logic [N_OUT-1:0][N_IN-1:0] pend_all;
    logic [WORD_BITS-1:0]       rdata_next;
    logic                       unused_wdata;

    // Only bit 0 of write data is stored
    assign unused_wdata = ^req_wdata[WORD_BITS-1:1];

    irq_addr_decode #(
        .N_IN(N_IN), .N_GROUPS(N_GROUPS), .LINES_PER_GROUP(LINES_PER_GROUP),
        .N_WORDS(N_WORDS), .ADDR_W(ADDR_W), .LINE_W(LINE_W),
        .IDX_W(IDX_W), .WSEL_W(WSEL_W)
    ) u_decode (
        .req_size (req_size),
        .req_addr (req_addr),
        .kind     (kind),
        .line     (line),
        .idx      (idx),
        .wsel     (wsel)
    );

    // Qualify the decoded access with the request strobes
    assign rd_en   = req_valid && !req_write;
    assign en_we   = req_valid && req_write && (kind == ACC_ENABLE);
    assign clr_req = rd_en && (kind == ACC_STATUS);

    // One state slice per output line
    for (genvar k = 0; k < N_OUT; k++) begin : g_line
        irq_line_slice #(
            .N_IN(N_IN), .IDX_W(IDX_W), .WSEL_W(WSEL_W)
        ) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_in   (irq_in),
            .en_we    (en_we && (line == LINE_W'(k))),
            .en_idx   (idx),
            .en_wbit  (req_wdata[0]),
            .clr_req  (clr_req && (line == LINE_W'(k))),
            .clr_wsel (wsel),
            .en_vec   (en_all[k]),
            .pend_vec (pend_all[k]),
            .irq_out  (irq_out[k])
        );
    end

    irq_read_mux #(
        .N_IN(N_IN), .N_OUT(N_OUT), .N_WORDS(N_WORDS),
        .LINE_W(LINE_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W)
    ) u_rmux (
        .rd_en      (rd_en),
        .kind       (kind),
        .line       (line),
        .idx        (idx),
        .wsel       (wsel),
        .en_all     (en_all),
        .pend_all   (pend_all),
        .rdata_next (rdata_next)
    );

    // Register the bus response one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= req_valid;
            resp_rdata <= rdata_next;
        end
    end

endmodule

// File: rtl/irq_router_chk.sv
// Module: property checker for the routing matrix, bound to its top.
// It observes the bus, the outputs and the per-line enable state.
module irq_router_chk #(
    parameter int N_IN            = 139,
    parameter int N_GROUPS        = 18,
    parameter int LINES_PER_GROUP = 4,
    parameter int ADDR_W          = 17
) (
    input logic                                              clk,
    input logic                                              rst_n,
    input logic [N_IN-1:0]                                   irq_in,
    input logic                                              req_valid,
    input logic                                              req_write,
    input logic                                              req_size,
    input logic [ADDR_W-1:0]                                 req_addr,
    input logic                                              resp_valid,
    input logic [63:0]                                       resp_rdata,
    input logic [N_GROUPS*LINES_PER_GROUP-1:0]               irq_out,
    input logic [N_GROUPS*LINES_PER_GROUP-1:0][N_IN-1:0]     en_all
);
    localparam int N_OUT     = N_GROUPS * LINES_PER_GROUP;
    localparam int N_WORDS   = (N_IN + 63) / 64;
    localparam int TOP_VALID = N_IN - (N_WORDS - 1) * 64;
    localparam logic [63:0] TOP_MASK = ~((64'd1 << TOP_VALID) - 64'd1);
    localparam logic [9:0]  TOP_OFF  = 10'(10'h120 + 8 * (N_WORDS - 1));

    // R1: the first cycle out of reset shows idle outputs and no response
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (irq_out == '0 && !resp_valid));

    // R11: every request is answered in the next cycle
    p_resp_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    // R11: no response without a request
    p_no_spurious_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    // R2: a byte read returns only bit 0
    p_enable_read_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_size) |=> (resp_rdata[63:1] == '0));

    // R10: bits beyond the input count in the last status word read as 0
    p_status_top_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size && req_addr[9:0] == TOP_OFF)
        |=> ((resp_rdata & TOP_MASK) == '0));

    // R6: an output only rises after an enabled input was seen high
    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        p_out_needs_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_out[k]) |-> $past(|(irq_in & en_all[k]), 2));
    end

endmodule

bind irq_router irq_router_chk #(
    .N_IN(N_IN), .N_GROUPS(N_GROUPS), .LINES_PER_GROUP(LINES_PER_GROUP),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_size   (req_size),
    .req_addr   (req_addr),
    .resp_valid (resp_valid),
    .resp_rdata (resp_rdata),
    .irq_out    (irq_out),
    .en_all     (en_all)
);

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
// Bench: a table of enable-register accesses, then directed tests of
// latching, clearing, routing independence and address corner cases.
module irq_router_bench;
    localparam int N_IN   = 139;
    localparam int N_OUT  = 72;
    localparam int ADDR_W = 17;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N_IN-1:0]   irq_in;
    logic              req_valid, req_write, req_size;
    logic [ADDR_W-1:0] req_addr;
    logic [63:0]       req_wdata;
    logic              resp_valid;
    logic [63:0]       resp_rdata;
    logic [N_OUT-1:0]  irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] rd;

    irq_router u_irq_router (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .irq_out(irq_out)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [63:0]       wdata;
        logic [63:0]       exp;
    } vec_t;

    // Byte accesses to enable registers: R2 storage, R9 window placement
    localparam vec_t TBL [12] = '{
        '{1'b1, 17'h00003, 64'h01, 64'h0},
        '{1'b0, 17'h00003, 64'h0,  64'h01},
        '{1'b1, 17'h01440, 64'hFF, 64'h0},
        '{1'b0, 17'h01440, 64'h0,  64'h01},
        '{1'b0, 17'h00440, 64'h0,  64'h00},
        '{1'b1, 17'h01440, 64'h02, 64'h0},
        '{1'b0, 17'h01440, 64'h0,  64'h00},
        '{1'b1, 17'h1188A, 64'h01, 64'h0},
        '{1'b0, 17'h1188A, 64'h0,  64'h01},
        '{1'b0, 17'h1108A, 64'h0,  64'h00},
        '{1'b1, 17'h00003, 64'h00, 64'h0},
        '{1'b0, 17'h00003, 64'h0,  64'h00}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus transaction; result sampled at the negedge after the response edge
    task automatic bus(input logic wr, input logic sz, input logic [ADDR_W-1:0] a,
                       input logic [63:0] wd, output logic [63:0] r);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        r = resp_rdata;
        check("R11 resp_valid after request", 64'(resp_valid), 64'd1);
    endtask

    function automatic logic [ADDR_W-1:0] win(input int g, input int j, input int off);
        return ADDR_W'(g * 'h1000 + j * 'h400 + off);
    endfunction

    task automatic set_en(input int g, input int j, input int n, input logic v);
        logic [63:0] dummy;
        bus(1'b1, 1'b0, win(g, j, n), {63'd0, v}, dummy);
    endtask

    task automatic rd_word(input int g, input int j, input int w, output logic [63:0] r);
        bus(1'b0, 1'b1, win(g, j, 'h120 + 8 * w), 64'd0, r);
    endtask

    // Raise the listed inputs for one cycle, then return them low
    task automatic pulse(input logic [N_IN-1:0] m);
        @(negedge clk); irq_in = m;
        @(negedge clk); irq_in = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_in = '0;
        req_valid = 1'b0; req_write = 1'b0; req_size = 1'b0;
        req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 outputs idle", 64'(irq_out == '0), 64'd1);
        check("R1 no response", 64'(resp_valid), 64'd0);
        for (int w = 0; w < 3; w++) begin
            rd_word(0, 0, w, rd);
            check("R1 status empty", rd, 64'd0);
        end
        bus(1'b0, 1'b0, win(3, 2, 100), 64'd0, rd);
        check("R1 enable cleared", rd, 64'd0);

        // Table walk: R2 and R9
        for (int i = 0; i < 12; i++) begin
            bus(TBL[i].wr, 1'b0, TBL[i].addr, TBL[i].wdata, rd);
            if (!TBL[i].wr) check("R2 R9 table entry", rd, TBL[i].exp);
        end

        // R3 R6: inputs 5, 70, 138 on line 0 land in all three words
        set_en(0, 0, 5, 1'b1);
        set_en(0, 0, 70, 1'b1);
        set_en(0, 0, 138, 1'b1);
        @(negedge clk);
        irq_in[5] = 1'b1; irq_in[70] = 1'b1; irq_in[138] = 1'b1;
        @(negedge clk);
        irq_in = '0;
        check("R6 output not yet high", 64'(irq_out[0]), 64'd0);
        @(negedge clk);
        check("R6 output high one cycle later", 64'(irq_out[0]), 64'd1);
        check("R8 input 138 also on line 70", 64'(irq_out[70]), 64'd1);
        check("R8 unrouted line idle", 64'(irq_out[1]), 64'd0);
        rd_word(0, 0, 0, rd); check("R3 word0 bit5", rd, 64'h20);
        rd_word(0, 0, 1, rd); check("R3 word1 bit6", rd, 64'h40);
        rd_word(0, 0, 2, rd); check("R3 R10 word2 bit10 only", rd, 64'h400);
        @(negedge clk);
        check("R4 R6 output low after clearing", 64'(irq_out[0]), 64'd0);
        rd_word(0, 0, 0, rd); check("R4 word0 cleared", rd, 64'd0);
        check("R8 line 70 kept its bit", 64'(irq_out[70]), 64'd1);
        rd_word(17, 2, 2, rd); check("R8 line 70 word2", rd, 64'h400);

        // R7: disabled input 6 latches nothing on line 0
        pulse(N_IN'(1) << 6);
        @(negedge clk);
        check("R7 disabled input no output", 64'(irq_out[0]), 64'd0);
        rd_word(0, 0, 0, rd); check("R7 disabled input no bit", rd, 64'd0);

        // R5: input 5 held high across clearing reads
        @(negedge clk); irq_in[5] = 1'b1;
        rd_word(0, 0, 0, rd); check("R5 first read", rd, 64'h20);
        rd_word(0, 0, 0, rd); check("R5 set wins over clear", rd, 64'h20);
        irq_in[5] = 1'b0;
        rd_word(0, 0, 0, rd); check("R5 last set still latched", rd, 64'h20);
        rd_word(0, 0, 0, rd); check("R4 cleared after input low", rd, 64'd0);

        // R8: input 20 routed to line 1 and line 9
        set_en(0, 1, 20, 1'b1);
        set_en(2, 1, 20, 1'b1);
        pulse(N_IN'(1) << 20);
        @(negedge clk);
        check("R8 line1 high", 64'(irq_out[1]), 64'd1);
        check("R8 line9 high", 64'(irq_out[9]), 64'd1);
        check("R8 line0 idle", 64'(irq_out[0]), 64'd0);
        rd_word(0, 1, 0, rd); check("R8 line1 bit20", rd, 64'h100000);
        rd_word(2, 1, 0, rd); check("R8 line9 untouched by line1 read", rd, 64'h100000);

        // R10: status writes ignored
        pulse(N_IN'(1) << 5);
        bus(1'b1, 1'b1, win(0, 0, 'h120), 64'd0, rd);
        bus(1'b1, 1'b1, win(0, 0, 'h128), {64{1'b1}}, rd);
        rd_word(0, 0, 0, rd); check("R10 write did not clear", rd, 64'h20);
        rd_word(0, 0, 1, rd); check("R10 write did not set", rd, 64'd0);

        // R11: unmapped offsets, wrong sizes, byte read of status
        bus(1'b1, 1'b0, win(0, 0, 'h200), 64'h01, rd);
        bus(1'b0, 1'b0, win(0, 0, 'h200), 64'd0, rd);
        check("R11 unmapped reads zero", rd, 64'd0);
        bus(1'b0, 1'b1, win(0, 0, 5), 64'd0, rd);
        check("R11 wide read of enable zero", rd, 64'd0);
        bus(1'b1, 1'b1, win(0, 0, 7), 64'd1, rd);
        bus(1'b0, 1'b0, win(0, 0, 7), 64'd0, rd);
        check("R11 wide write of enable ignored", rd, 64'd0);
        pulse(N_IN'(1) << 5);
        bus(1'b0, 1'b0, win(0, 0, 'h120), 64'd0, rd);
        check("R11 byte read of status zero", rd, 64'd0);
        rd_word(0, 0, 0, rd); check("R11 byte read did not clear", rd, 64'h20);
        @(negedge clk);
        check("R11 no response when idle", 64'(resp_valid), 64'd0);

        // R1: reset with pending bits and enables set
        pulse(N_IN'(1) << 5);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset drops outputs", 64'(irq_out == '0), 64'd1);
        rd_word(0, 0, 0, rd); check("R1 reset clears pending", rd, 64'd0);
        bus(1'b0, 1'b0, win(0, 0, 5), 64'd0, rd);
        check("R1 reset clears enable", rd, 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule